// File: doc/BRIEF.md
# End-Of-Chain Error Responder

This block stands in for a target that will never answer. It is used when a non-posted request cannot be completed, either because its address decodes to nothing or because the addressed target has given up. The block takes one request descriptor at a time: a command code, a tag, a count of data dwords and a flag that tells a non-existent address apart from a failing target. It then builds the error completion the requester is waiting for.

The completion leaves on a valid/ready stream. It starts with one header beat carrying the tag and two error bits, Error and NXA. Read-class commands are followed by a full-length payload of all-ones filler dwords. Every buffer along the return path sees the whole transfer it reserved room for, so it can release that space. Posted commands that fail are absorbed and produce no response. The request side is stalled until the final beat of the current completion has been accepted.

Top module: `eoc_err_responder`

## Requirements
- R1: While reset is asserted, and on the cycles after it has been released, `rsp_valid` is 0. Once release has passed the internal synchroniser, `req_ready` is 1.
- R2: A request with `req_nxa`=1 gets a header with bit 0 (Error) = 1 and bit 1 (NXA) = 1.
- R3: A request with `req_nxa`=0 gets a header with bit 0 (Error) = 1 and bit 1 (NXA) = 0.
- R4: The header beat has `rsp_hdr`=1. Its bit 2 is 1 (read response) for command codes 0 (sized read) and 1 (atomic read-modify-write), and 0 (target done) for codes 2 (non-posted write) and 3 (flush). Bits [3 +: TAG_W] carry `req_tag` unchanged, and all remaining bits are 0.
- R5: For command codes 0 and 1, the header is followed by exactly `req_count`+1 data beats. Each has `rsp_hdr`=0 and `rsp_data` all ones, so a count of 0 gives 1 dword and a count of 15 gives 16.
- R6: `rsp_last` is 1 on the header of a target-done response. For read responses it is 1 only on the final data beat.
- R7: Command codes 4 (posted write) and 5 to 7 are accepted but produce no beat, and `req_ready` stays 1 on the following cycle.
- R8: `req_ready` is 0 from the cycle after a responding request is accepted until the cycle after its last beat is accepted. In that cycle it returns to 1.
- R9: The header is presented the cycle after acceptance. A beat with `rsp_valid`=1 and `rsp_ready`=0 is held unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request descriptor valid |
| req_ready | output | 1 | Block can take a request |
| req_cmd | input | 3 | Command code (0 read, 1 atomic, 2 non-posted write, 3 flush, 4 to 7 no response) |
| req_tag | input | TAG_W | Request tag |
| req_count | input | CNT_W | Data dwords minus one |
| req_nxa | input | 1 | 1 = non-existent address, 0 = target failure |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Sink accepts the beat |
| rsp_hdr | output | 1 | Beat is the header |
| rsp_last | output | 1 | Final beat of the response |
| rsp_data | output | DATA_W | Header word or filler dword |

## Verification
A request accepted at a clock edge puts its header on the outputs after that same edge. So the header must be visible in the half-cycle that follows, and every further beat appears one edge after the previous beat's handshake. The bench changes inputs shortly after each rising edge and samples at the falling edge. There, its queue-based model gives the expected `req_ready`, `rsp_valid` and front beat for that exact cycle, and the model then advances on the handshakes it has just seen. Sink back-pressure is varied between always-ready and random stalls, so hold behaviour and the ready release after the last beat are checked at each cycle where they are due.

// File: rtl/eoc_pkg.sv
package eoc_pkg;
  typedef enum logic [2:0] {
    CMD_RD_SIZED  = 3'd0,
    CMD_ATOMIC    = 3'd1,
    CMD_WR_NP     = 3'd2,
    CMD_FLUSH     = 3'd3,
    CMD_WR_POSTED = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2
  } rsp_state_e;

  localparam int HDR_ERR_BIT  = 0;
  localparam int HDR_NXA_BIT  = 1;
  localparam int HDR_KIND_BIT = 2;
  localparam int HDR_TAG_LSB  = 3;
endpackage

// File: rtl/eoc_req_classify.sv
module eoc_req_classify
  import eoc_pkg::*;
(
  input  logic [2:0] cmd,
  output logic       needs_rsp,
  output logic       has_data
);
  always_comb begin
    needs_rsp = 1'b0;
    has_data  = 1'b0;
    case (cmd_e'(cmd))
      CMD_RD_SIZED, CMD_ATOMIC: begin
        needs_rsp = 1'b1;
        has_data  = 1'b1;
      end
      CMD_WR_NP, CMD_FLUSH: begin
        needs_rsp = 1'b1;
      end
      default: begin
        needs_rsp = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/eoc_hdr_fmt.sv
module eoc_hdr_fmt
  import eoc_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [TAG_W-1:0]  tag,
  input  logic              nxa,
  input  logic              is_read,
  output logic [DATA_W-1:0] word
);
  always_comb begin
    word                         = '0;
    word[HDR_ERR_BIT]            = 1'b1;
    word[HDR_NXA_BIT]            = nxa;
    word[HDR_KIND_BIT]           = is_read;
    word[HDR_TAG_LSB +: TAG_W]   = tag;
  end
endmodule

// File: rtl/eoc_beat_ctr.sv
module eoc_beat_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             is_zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/eoc_err_responder.sv
module eoc_err_responder
  import eoc_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int CNT_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_cmd,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_nxa,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hdr,
  output logic              rsp_last,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int SYNC_STAGES = 2;

  // reset: asserts at once, releases through a short synchroniser
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  rsp_state_e       state_q, state_d;
  logic [TAG_W-1:0] tag_q;
  logic             nxa_q, rd_q;
  logic             cap_en;
  logic             need_rsp, need_data;
  logic             accept, beat_done;
  logic             cnt_zero;
  logic [DATA_W-1:0] hdr_word;

  eoc_req_classify u_classify (
    .cmd       (req_cmd),
    .needs_rsp (need_rsp),
    .has_data  (need_data)
  );

  eoc_hdr_fmt #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_hdr (
    .tag     (tag_q),
    .nxa     (nxa_q),
    .is_read (rd_q),
    .word    (hdr_word)
  );

  assign req_ready = (state_q == ST_IDLE) && rst_sync_n;
  assign accept    = req_valid && req_ready;
  assign beat_done = rsp_valid && rsp_ready;
  assign cap_en    = accept && need_rsp;

  eoc_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (cap_en),
    .load_val (req_count),
    .dec      (beat_done && (state_q == ST_DATA)),
    .is_zero  (cnt_zero)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (cap_en) state_d = ST_HDR;
      ST_HDR:  if (beat_done) state_d = rd_q ? ST_DATA : ST_IDLE;
      ST_DATA: if (beat_done && cnt_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tag_q <= '0;
      nxa_q <= 1'b0;
      rd_q  <= 1'b0;
    end else if (cap_en) begin
      tag_q <= req_tag;
      nxa_q <= req_nxa;
      rd_q  <= need_data;
    end
  end

  always_comb begin
    rsp_valid = (state_q != ST_IDLE);
    rsp_hdr   = (state_q == ST_HDR);
    rsp_data  = rsp_hdr ? hdr_word : '1;
    rsp_last  = rsp_hdr ? !rd_q : ((state_q == ST_DATA) && cnt_zero);
  end
endmodule

// File: rtl/eoc_err_responder_chk.sv
module eoc_err_responder_chk #(
  parameter int TAG_W  = 5,
  parameter int CNT_W  = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_cmd,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hdr,
  input logic              rsp_last,
  input logic [DATA_W-1:0] rsp_data
);
  p_err_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hdr |-> rsp_data[0]);

  p_filler_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hdr |-> (rsp_data == {DATA_W{1'b1}}));

  p_posted_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_cmd >= 3'd4) |=> !rsp_valid && req_ready);

  p_busy_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && rsp_last |=> req_ready && !rsp_valid);

  p_hdr_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_cmd < 3'd4) |=> rsp_valid && rsp_hdr);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) &&
                                $stable(rsp_hdr) && $stable(rsp_last));
endmodule

bind eoc_err_responder eoc_err_responder_chk #(
  .TAG_W(TAG_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_cmd   (req_cmd),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_hdr   (rsp_hdr),
  .rsp_last  (rsp_last),
  .rsp_data  (rsp_data)
);

// File: tb/eoc_err_responder_bench.sv
module eoc_err_responder_bench;
  localparam int TAG_W  = 5;
  localparam int CNT_W  = 4;
  localparam int DATA_W = 32;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [2:0]        req_cmd;
  logic [TAG_W-1:0]  req_tag;
  logic [CNT_W-1:0]  req_count;
  logic              req_nxa;
  logic              rsp_valid;
  logic              rsp_ready;
  logic              rsp_hdr;
  logic              rsp_last;
  logic [DATA_W-1:0] rsp_data;

  int checks;
  int failures;
  bit chk_en;
  bit done;
  int stall_mode;

  logic [DATA_W-1:0] q_data[$];
  bit                q_hdr[$];
  bit                q_last[$];

  eoc_err_responder #(.TAG_W(TAG_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_eoc_err_responder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_tag(req_tag), .req_count(req_count), .req_nxa(req_nxa),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hdr(rsp_hdr),
    .rsp_last(rsp_last), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: compare at the falling edge, then advance on the handshakes seen
  always @(negedge clk) begin
    if (chk_en) begin
      bit busy;
      bit acc;
      bit pop;
      busy = (q_data.size() != 0);
      check(req_ready == !busy, "R8", req_ready, !busy);
      check(rsp_valid == busy, "R9", rsp_valid, busy);
      if (busy && rsp_valid) begin
        check(rsp_hdr == q_hdr[0], "R4", rsp_hdr, q_hdr[0]);
        if (q_hdr[0])
          check(rsp_data == q_data[0], q_data[0][1] ? "R2" : "R3", rsp_data, q_data[0]);
        else
          check(rsp_data == q_data[0], "R5", rsp_data, q_data[0]);
        check(rsp_last == q_last[0], "R6", rsp_last, q_last[0]);
      end
      acc = req_valid && req_ready;
      pop = rsp_valid && rsp_ready;
      if (pop && busy) begin
        void'(q_data.pop_front());
        void'(q_hdr.pop_front());
        void'(q_last.pop_front());
      end
      if (acc && req_cmd < 3'd4) begin
        logic [DATA_W-1:0] w;
        bit rd;
        rd = (req_cmd < 3'd2);
        w = '0;
        w[0] = 1'b1;
        w[1] = req_nxa;
        w[2] = rd;
        w[3 +: TAG_W] = req_tag;
        q_data.push_back(w);
        q_hdr.push_back(1'b1);
        q_last.push_back(!rd);
        if (rd) begin
          for (int i = 0; i <= int'(req_count); i++) begin
            q_data.push_back({DATA_W{1'b1}});
            q_hdr.push_back(1'b0);
            q_last.push_back(i == int'(req_count));
          end
        end
      end
    end
  end

  // sink back-pressure, changed just after each rising edge
  always @(posedge clk) begin
    #2;
    if (stall_mode == 0) rsp_ready <= 1'b1;
    else if (stall_mode == 1) rsp_ready <= ($urandom_range(0, 2) != 0);
    else rsp_ready <= ($urandom_range(0, 3) == 0);
  end

  task automatic send(input int cmd, input int tag, input int cnt, input bit nxa);
    @(posedge clk);
    #2;
    req_valid = 1'b1;
    req_cmd   = 3'(cmd);
    req_tag   = TAG_W'(tag);
    req_count = CNT_W'(cnt);
    req_nxa   = nxa;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #2;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_data.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; chk_en = 0; done = 0; stall_mode = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_tag = '0;
    req_count = '0; req_nxa = 1'b0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1", rsp_valid, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rsp_valid == 1'b0, "R1", rsp_valid, 0);
    check(req_ready == 1'b1, "R1", req_ready, 1);
    chk_en = 1;

    // directed cases
    send(0, 3, 0, 1'b1);  drain();   // R2 read, single dword
    send(0, 7, 15, 1'b0); drain();   // R3 R5 read, sixteen dwords
    send(1, 31, 3, 1'b1); drain();   // atomic
    send(2, 9, 5, 1'b0);  drain();   // R6 target done
    send(3, 0, 0, 1'b1);  drain();   // flush
    for (int c = 4; c < 8; c++) begin
      send(c, c, 2, 1'b1);
      @(negedge clk);
      check(rsp_valid == 1'b0, "R7", rsp_valid, 0);
      check(req_ready == 1'b1, "R7", req_ready, 1);
    end

    // back-pressure on a long read, then mixed traffic
    stall_mode = 2;
    send(0, 12, 15, 1'b0); drain();
    send(2, 13, 0, 1'b1);  drain();
    for (int m = 0; m < 3; m++) begin
      stall_mode = m;
      for (int n = 0; n < 60; n++) begin
        send($urandom_range(0, 7), $urandom_range(0, 31),
             $urandom_range(0, 15), 1'($urandom_range(0, 1)));
      end
      drain();
    end
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule